// File: doc/BRIEF.md
# External Interrupt Request Detector

This block is the front end for off-chip interrupt requests. It watches eight maskable request pins and one non-maskable pin. Each maskable pin is brought into the clock domain through a two-stage synchronizer. A sense mode chosen per pin then decides which pin activity counts as a request. A detected request sets a sticky status flag. Only software can clear that flag, and it must first read the flag as 1. The pin's enable bit decides whether the flag is passed on as a request.

The enabled flags are ranked by a programmable priority level per pin, and the winner is shown on a pending-request output. The non-maskable pin fires a one-cycle request on its selected edge. That request is never masked and carries a fixed vector number. A wake-up output combines the requests that may bring the device out of standby. Pins 0 to 2 and the non-maskable pin always count toward wake-up. Pins 3 to 7 count only when a select bit is set.

Top module: `ext_irq_front`

## Requirements
- R1: Each pin n has a 2-bit sense field at bits [2n+1:2n] of register 0: 00 sets the flag on every cycle the synchronized pin is 0; 01 sets it on a falling edge; 10 on a rising edge; 11 on either edge. Pin inputs pass two synchronizer flops before detection.
- R2: Register 1 bit n is pin n's enable. `irq_req[n]` is 1 exactly when flag n and enable n are both 1. A disabled pin still latches its flag, and that flag is readable in register 2.
- R3: Register 2 shows the flags. Writing 0 to a flag bit clears it only if a read of register 2 returned that bit as 1 since the last clear of that bit. Writing 0 without a prior read leaves the flag set. Writing 1 has no effect.
- R4: A detection in the same cycle as a clear wins, so the flag stays 1. A low-level pin held low can therefore not be cleared.
- R5: Register 4 bit 0 selects the non-maskable edge: 0 = falling, 1 = rising. `nmi_req` pulses for exactly one cycle per selected edge and never on the other edge.
- R6: `nmi_req` does not depend on any enable bit. `nmi_vector` always reads 7.
- R7: Register 3 holds a 3-bit priority per pin at bits [3n+2:3n]; a larger value means higher priority. `pend_valid` is 1 when any `irq_req` bit is set. `pend_pin` and `pend_level` then name the highest-priority requesting pin. On a tie, the lower pin number wins.
- R8: `wake` is 1 when `nmi_req` is 1 or any of `irq_req[2:0]` is set. `irq_req[7:3]` count toward `wake` only when register 4 bit 1 is 1.
- R9: After reset, all registers read 0 and all flags are 0. The synchronizers start at 1, so pins idle high. `irq_req`, `pend_valid`, `nmi_req` and `wake` are 0.
- R10: Registers 0, 1, 3 and 4 read back what was last written, zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 8 | Asynchronous maskable request pins |
| nmi_pin | input | 1 | Asynchronous non-maskable request pin |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (arms flag clears on register 2) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_req | output | 8 | Per-pin enabled requests |
| pend_valid | output | 1 | Some maskable request is pending |
| pend_pin | output | 3 | Winning pin number |
| pend_level | output | 3 | Winning pin's priority |
| nmi_req | output | 1 | One-cycle non-maskable request |
| nmi_vector | output | 8 | Vector number of the non-maskable request |
| wake | output | 1 | Standby wake-up request |

## Verification
Some behaviours are checked by assertions on every cycle:
- a flag falls only after an armed clear;
- a flag rises only after a detection;
- a detection always leaves the flag set;
- the pending pin and level agree with the requests and priorities;
- the non-maskable pulse lasts one cycle;
- the ungated pins always raise wake-up.

Other behaviours only the bench scenarios can show:
- which pin waveform should have set which flag under each sense mode;
- that an unread flag survives a write of 0;
- that the non-maskable pin ignores its unselected edge;
- that the wake-up gate follows the select bit.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_SENSE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_ENABLE = 3'd1;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd2;
  localparam logic [ADDR_W-1:0] A_PRIO   = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;

  // Detection decision for one pin given current and previous synchronized sample
  function automatic logic sense_hit(sense_e mode, logic cur, logic prv);
    case (mode)
      SENSE_LOW:  return !cur;
      SENSE_FALL: return prv && !cur;
      SENSE_RISE: return !prv && cur;
      default:    return prv != cur;
    endcase
  endfunction

  function automatic logic edge_hit(logic rise_sel, logic cur, logic prv);
    return rise_sel ? (!prv && cur) : (prv && !cur);
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prv
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '1;
      cur  <= '1;
      prv  <= '1;
    end else begin
      meta <= din;
      cur  <= meta;
      prv  <= cur;
    end
  end
endmodule

// File: rtl/irq_channel.sv
module irq_channel (
  input  logic                  clk,
  input  logic                  rst_n,
  input  ext_irq_pkg::sense_e   mode,
  input  logic                  cur,
  input  logic                  prv,
  input  logic                  clr,
  output logic                  det,
  output logic                  flag
);
  assign det = ext_irq_pkg::sense_hit(mode, cur, prv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (det) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NPINS  = 8,
  parameter int PRIO_W = 3,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic [NPINS-1:0]        req,
  input  logic [NPINS*PRIO_W-1:0] prio,
  output logic                    valid,
  output logic [IDX_W-1:0]        idx,
  output logic [PRIO_W-1:0]       level
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    level = '0;
    // scan from the top so that a lower pin replaces on a tie
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (req[i] && (!valid || prio[i*PRIO_W +: PRIO_W] >= level)) begin
        valid = 1'b1;
        idx   = IDX_W'(i);
        level = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/ext_irq_front.sv
module ext_irq_front #(
  parameter int NPINS     = 8,
  parameter int PRIO_W    = 3,
  parameter int WAKE_FREE = 3,
  parameter int VEC_W     = 8,
  parameter int NMI_VEC   = 7
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NPINS-1:0]                  irq_pin,
  input  logic                              nmi_pin,
  input  logic [ext_irq_pkg::ADDR_W-1:0]    reg_addr,
  input  logic                              reg_wr,
  input  logic                              reg_rd,
  input  logic [ext_irq_pkg::DATA_W-1:0]    reg_wdata,
  output logic [ext_irq_pkg::DATA_W-1:0]    reg_rdata,
  output logic [NPINS-1:0]                  irq_req,
  output logic                              pend_valid,
  output logic [$clog2(NPINS)-1:0]          pend_pin,
  output logic [PRIO_W-1:0]                 pend_level,
  output logic                              nmi_req,
  output logic [VEC_W-1:0]                  nmi_vector,
  output logic                              wake
);
  import ext_irq_pkg::*;

  localparam int SENSE_W = 2 * NPINS;
  localparam int PCFG_W  = PRIO_W * NPINS;

  logic [SENSE_W-1:0] sense_cfg;
  logic [NPINS-1:0]   enable;
  logic [PCFG_W-1:0]  prio_cfg;
  logic               nmi_rise;
  logic               wake_sel;
  logic [NPINS-1:0]   armed;

  logic [NPINS-1:0]   pin_cur, pin_prv;
  logic               nmi_cur, nmi_prv;
  logic [NPINS-1:0]   det;
  logic [NPINS-1:0]   flags;
  logic [NPINS-1:0]   clr_mask;
  logic [NPINS-1:0]   wake_mask;
  logic               wr_flags, rd_flags;

  assign wr_flags = reg_wr && (reg_addr == A_FLAGS);
  assign rd_flags = reg_rd && (reg_addr == A_FLAGS);
  assign clr_mask = wr_flags ? (armed & ~reg_wdata[NPINS-1:0]) : '0;

  // configuration registers and read arming
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_cfg <= '0;
      enable    <= '0;
      prio_cfg  <= '0;
      nmi_rise  <= 1'b0;
      wake_sel  <= 1'b0;
      armed     <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_SENSE:  sense_cfg <= reg_wdata[SENSE_W-1:0];
          A_ENABLE: enable    <= reg_wdata[NPINS-1:0];
          A_PRIO:   prio_cfg  <= reg_wdata[PCFG_W-1:0];
          A_CTRL: begin
            nmi_rise <= reg_wdata[0];
            wake_sel <= reg_wdata[1];
          end
          default: ;
        endcase
      end
      if (rd_flags)      armed <= flags;
      else if (wr_flags) armed <= armed & ~clr_mask;
    end
  end

  always_comb begin
    case (reg_addr)
      A_SENSE:  reg_rdata = DATA_W'(sense_cfg);
      A_ENABLE: reg_rdata = DATA_W'(enable);
      A_FLAGS:  reg_rdata = DATA_W'(flags);
      A_PRIO:   reg_rdata = DATA_W'(prio_cfg);
      A_CTRL:   reg_rdata = DATA_W'({wake_sel, nmi_rise});
      default:  reg_rdata = '0;
    endcase
  end

  irq_sync #(.W(NPINS + 1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({nmi_pin, irq_pin}),
    .cur   ({nmi_cur, pin_cur}),
    .prv   ({nmi_prv, pin_prv})
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_chan
    irq_channel u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (sense_e'(sense_cfg[2*g +: 2])),
      .cur   (pin_cur[g]),
      .prv   (pin_prv[g]),
      .clr   (clr_mask[g]),
      .det   (det[g]),
      .flag  (flags[g])
    );
    if (g < WAKE_FREE) begin : g_free
      assign wake_mask[g] = 1'b1;
    end else begin : g_gated
      assign wake_mask[g] = wake_sel;
    end
  end

  assign irq_req    = flags & enable;
  assign nmi_req    = edge_hit(nmi_rise, nmi_cur, nmi_prv);
  assign nmi_vector = VEC_W'(NMI_VEC);
  assign wake       = nmi_req || |(irq_req & wake_mask);

  irq_prio_pick #(.NPINS(NPINS), .PRIO_W(PRIO_W)) u_pick (
    .req   (irq_req),
    .prio  (prio_cfg),
    .valid (pend_valid),
    .idx   (pend_pin),
    .level (pend_level)
  );
endmodule

// File: rtl/ext_irq_front_chk.sv
module ext_irq_front_chk #(
  parameter int NPINS     = 8,
  parameter int PRIO_W    = 3,
  parameter int WAKE_FREE = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NPINS-1:0]          flags,
  input logic [NPINS-1:0]          det,
  input logic [NPINS-1:0]          clr_mask,
  input logic [NPINS-1:0]          irq_req,
  input logic [NPINS*PRIO_W-1:0]   prio_cfg,
  input logic                      pend_valid,
  input logic [$clog2(NPINS)-1:0]  pend_pin,
  input logic [PRIO_W-1:0]         pend_level,
  input logic                      nmi_req,
  input logic                      wake
);
  localparam logic [NPINS-1:0] FREE_MASK = NPINS'((1 << WAKE_FREE) - 1);

  assert_flag_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (~flags & $past(flags) & ~$past(clr_mask)) == '0);

  assert_flag_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~$past(flags) & ~$past(det)) == '0);

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(det) & ~flags) == '0);

  assert_pend_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> (irq_req[pend_pin] && pend_level == prio_cfg[pend_pin*PRIO_W +: PRIO_W]));

  assert_pend_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_valid |-> irq_req == '0);

  assert_nmi_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req);

  assert_wake_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req || (irq_req & FREE_MASK) != '0) |-> wake);
endmodule

bind ext_irq_front ext_irq_front_chk #(
  .NPINS(NPINS), .PRIO_W(PRIO_W), .WAKE_FREE(WAKE_FREE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flags(flags), .det(det), .clr_mask(clr_mask),
  .irq_req(irq_req), .prio_cfg(prio_cfg), .pend_valid(pend_valid),
  .pend_pin(pend_pin), .pend_level(pend_level), .nmi_req(nmi_req), .wake(wake)
);

// File: tb/ext_irq_front_tb.sv
module ext_irq_front_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_pin = 8'hFF;
  logic        nmi_pin = 1'b1;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  irq_req;
  logic        pend_valid;
  logic [2:0]  pend_pin, pend_level;
  logic        nmi_req;
  logic [7:0]  nmi_vector;
  logic        wake;

  int checks = 0, errors = 0, nmi_cnt = 0;
  bit nmi_wake_ok = 1'b1;

  always #2 clk = ~clk;

  ext_irq_front u_dut (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .nmi_pin(nmi_pin),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .pend_valid(pend_valid),
    .pend_pin(pend_pin), .pend_level(pend_level), .nmi_req(nmi_req),
    .nmi_vector(nmi_vector), .wake(wake)
  );

  always @(posedge clk) if (rst_n && nmi_req) begin
    nmi_cnt++;
    if (!wake) nmi_wake_ok = 1'b0;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    logic [31:0] d;
    rd(3'd2, d);
    wr(3'd2, 32'h0);
  endtask

  function automatic bit model_hit(logic [1:0] m, bit o, bit v);
    if (m == 2'b00) return v == 1'b0;
    if (m == 2'b01) return o && !v;
    if (m == 2'b10) return !o && v;
    return o != v;
  endfunction

  function automatic logic [6:0] model_pick(logic [7:0] req, logic [23:0] pr);
    bit found = 0; int best = 0; int lvl = 0;
    for (int i = 0; i < 8; i++) begin
      int p = int'(pr[3*i +: 3]);
      if (req[i] && (!found || p > lvl)) begin found = 1; best = i; lvl = p; end
    end
    return {found, 3'(best), 3'(lvl)};
  endfunction

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    settle();

    // R9 reset state
    for (int a = 0; a < 5; a++) begin rd(3'(a), d); chk("R9 reg", d, 0); end
    chk("R9 irq_req", 32'(irq_req), 0);
    chk("R9 pend_valid", 32'(pend_valid), 0);
    chk("R9 wake", 32'(wake), 0);
    chk("R6 vector", 32'(nmi_vector), 7);

    // R10 readback
    wr(3'd0, 32'hFFFF_A5C3); rd(3'd0, d); chk("R10 sense", d, 32'h0000_A5C3);
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, d); chk("R10 prio", d, 32'h00FF_FFFF);
    wr(3'd4, 32'h7);         rd(3'd4, d); chk("R10 ctrl", d, 32'h3);
    wr(3'd4, 32'h0);

    // R1 falling mode on pin 0, R2 disabled flag still latches
    wr(3'd0, 32'h5555); wr(3'd1, 32'h0); clear_all();
    irq_pin[0] = 1'b0; settle(); irq_pin[0] = 1'b1; settle();
    rd(3'd2, d); chk("R1 falling latch", d, 32'h1);
    chk("R2 disabled req", 32'(irq_req), 0);
    wr(3'd1, 32'h1); chk("R2 enabled req", 32'(irq_req), 32'h1);

    // R3 clear rules
    clear_all(); d = 32'(irq_req); // fresh start
    irq_pin[0] = 1'b0; settle(); irq_pin[0] = 1'b1; settle();
    wr(3'd2, 32'h0); rd(3'd2, d); chk("R3 unread write0 keeps", d, 32'h1);
    wr(3'd2, 32'hFF); rd(3'd2, d); chk("R3 write1 keeps", d, 32'h1);
    wr(3'd2, 32'h0); rd(3'd2, d); chk("R3 armed write0 clears", d, 32'h0);

    // R4 set wins: pin 1 low-level held low
    wr(3'd0, 32'h0); wr(3'd1, 32'h2); irq_pin[1] = 1'b0; settle();
    clear_all(); rd(3'd2, d); chk("R4 held level survives clear", d & 32'h2, 32'h2);
    irq_pin[1] = 1'b1; settle(); clear_all(); rd(3'd2, d);
    chk("R4 released clears", d, 32'h0);

    // R5/R6 non-maskable edge select, independent of enables
    wr(3'd1, 32'h0); base = nmi_cnt;
    nmi_pin = 1'b0; settle(); chk("R5 falling fires", nmi_cnt - base, 1);
    nmi_pin = 1'b1; settle(); chk("R5 rising ignored", nmi_cnt - base, 1);
    wr(3'd4, 32'h1); base = nmi_cnt;
    nmi_pin = 1'b0; settle(); chk("R5 falling ignored", nmi_cnt - base, 0);
    nmi_pin = 1'b1; settle(); chk("R6 rising fires unmasked", nmi_cnt - base, 1);
    chk("R8 nmi wakes", 32'(nmi_wake_ok), 1);

    // R8 wake gating on pin 5 and pin 2
    wr(3'd4, 32'h0); wr(3'd0, 32'hAAAA); wr(3'd1, 32'h24); clear_all();
    irq_pin[5] = 1'b0; settle(); irq_pin[5] = 1'b1; settle();
    chk("R8 pin5 req", 32'(irq_req), 32'h20);
    chk("R8 pin5 gated", 32'(wake), 0);
    wr(3'd4, 32'h2); chk("R8 pin5 selected", 32'(wake), 1);
    wr(3'd4, 32'h0); clear_all();
    irq_pin[2] = 1'b0; settle(); irq_pin[2] = 1'b1; settle();
    chk("R8 pin2 free", 32'(wake), 1);

    // R7 tie: pins 2 and 6 both at level 5
    wr(3'd3, 32'(5 << 6) | 32'(5 << 18)); wr(3'd1, 32'h44); clear_all();
    irq_pin[2] = 1'b0; irq_pin[6] = 1'b0; settle();
    irq_pin[2] = 1'b1; irq_pin[6] = 1'b1; settle();
    chk("R7 tie pin", {pend_valid, pend_pin, pend_level}, {1'b1, 3'd2, 3'd5});

    // random rounds over R1, R2, R7, R8
    for (int r = 0; r < 20; r++) begin
      logic [15:0] sense = 16'($urandom);
      logic [7:0]  en    = 8'($urandom);
      logic [23:0] pr    = 24'($urandom);
      logic        ws    = 1'($urandom);
      logic [7:0]  exp_f = '0;
      logic [7:0]  old_p = 8'hFF;
      irq_pin = 8'hFF; settle();
      wr(3'd0, 32'(sense)); wr(3'd1, 32'(en)); wr(3'd3, 32'(pr));
      wr(3'd4, {30'b0, ws, 1'b1});
      clear_all();
      for (int s = 0; s < 12; s++) begin
        logic [7:0] np = 8'($urandom);
        irq_pin = np; settle();
        for (int i = 0; i < 8; i++)
          if (model_hit(sense[2*i +: 2], old_p[i], np[i]) ||
              model_hit(sense[2*i +: 2], np[i], np[i]))
            exp_f[i] = 1'b1;
        old_p = np;
      end
      rd(3'd2, d);
      chk("R1 random flags", d, 32'(exp_f));
      chk("R2 random req", 32'(irq_req), 32'(exp_f & en));
      chk("R7 random pick", {pend_valid, pend_pin, pend_level},
          model_pick(exp_f & en, pr));
      chk("R8 random wake", 32'(wake),
          32'(|(exp_f & en & {{5{ws}}, 3'b111})));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule